// File: doc/BRIEF.md
# One-Position Shift Unit with Sign-Change Detection

This block moves a data word by exactly one bit position, or leaves it as it is, in a single combinational pass. A two-bit operation select chooses between holding the word, moving it toward the least significant end, or moving it toward the most significant end. A separate mode input decides whether the word is treated as an unsigned bit pattern (zero fill on both ends) or as a two's-complement number (the sign is kept on a move toward the least significant end).

When a signed word is doubled and the result changes sign, the product no longer fits. The block reports this on a single flag, whether a negative value turned positive or a positive value turned negative. Each output bit is picked by its own four-way selector, indexed by the operation select, so the logic depth does not depend on the word width. The unit has no clock and no reset. It is meant to sit inside a datapath stage that registers its output.

Top module: `shift1_unit`

## Requirements
- R1: With `shift_en` = 0, `dout` equals `din` for any value of `shift_left` and `arith_mode`, and `ovf_flag` is 0.
- R2: With `shift_en` = 1, `shift_left` = 0 and `arith_mode` = 0, `dout` is `din` moved one place toward bit 0. Bit 0 of `din` is lost and `dout[WIDTH-1]` is 0.
- R3: With `shift_en` = 1 and `shift_left` = 1, `dout` is `din` moved one place toward the MSB. `din[WIDTH-1]` is lost and `dout[0]` is 0. This holds for both values of `arith_mode`.
- R4: With `shift_en` = 1, `shift_left` = 0 and `arith_mode` = 1, `dout[WIDTH-1]` repeats `din[WIDTH-1]`. The signed value of `dout` is then the floor of the signed input divided by two; for example, 8-bit 11111011 gives 11111101.
- R5: With `shift_en` = 1, `shift_left` = 1 and `arith_mode` = 1, `ovf_flag` is 1 exactly when the sign bit of `dout` differs from the sign bit of `din`. This covers a negative input becoming positive (10111111 gives 01111110) and a positive input becoming negative (01000010 gives 10000100).
- R6: `ovf_flag` is 0 whenever `arith_mode` = 0 or `shift_left` = 0, for every `din`.
- R7: The word width is the parameter `WIDTH` (at least 2, default 4). R1 to R6 hold at the default width and at 8 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| din | input | WIDTH | Word to be shifted |
| shift_en | input | 1 | Operation select, upper bit: 0 holds the word, 1 shifts it |
| shift_left | input | 1 | Operation select, lower bit: 1 toward MSB, 0 toward bit 0 |
| arith_mode | input | 1 | 0 unsigned (zero fill), 1 two's-complement |
| dout | output | WIDTH | Shifted word |
| ovf_flag | output | 1 | Sign changed on a signed doubling |

## Verification
Every input word is tried against every combination of the select and mode bits, at 4 and at 8 bits. The hold cases with `shift_left` toggled show that the direction bit is ignored when shifting is off. Words with the MSB set show the difference between zero fill and sign fill on right shifts, which separates R2 from R4. Words whose two top bits are 01 or 10 show the flag firing in each direction of sign change, while words with 00 or 11 on top, and the same words in unsigned mode, show that it stays low.

// File: rtl/shift1_pkg.sv
package shift1_pkg;

  // Operation select {shift_en, shift_left}
  typedef enum logic [1:0] {
    OP_HOLD_A = 2'b00,
    OP_HOLD_B = 2'b01,
    OP_RIGHT  = 2'b10,
    OP_LEFT   = 2'b11
  } shift_op_e;

  // Bit that enters at the MSB on a right move
  function automatic logic right_fill(input logic msb, input logic signed_mode);
    return signed_mode & msb;
  endfunction

  // Signed doubling overflows when the two top input bits disagree
  function automatic logic sign_escape(input logic top, input logic next);
    return top ^ next;
  endfunction

endpackage

// File: rtl/shift1_fill.sv
module shift1_fill (
  input  logic msb_in,
  input  logic arith_mode,
  output logic fill_bit
);
  import shift1_pkg::*;

  always_comb begin
    fill_bit = right_fill(msb_in, arith_mode);
  end
endmodule

// File: rtl/shift1_lane.sv
module shift1_lane (
  input  logic [1:0] op_sel,
  input  logic       self_bit,
  input  logic       from_above,
  input  logic       from_below,
  output logic       lane_out
);
  import shift1_pkg::*;

  shift_op_e op;

  always_comb begin
    op = shift_op_e'(op_sel);
    unique case (op)
      OP_HOLD_A: lane_out = self_bit;
      OP_HOLD_B: lane_out = self_bit;
      OP_RIGHT:  lane_out = from_above;
      OP_LEFT:   lane_out = from_below;
      default:   lane_out = self_bit;
    endcase
  end
endmodule

// File: rtl/shift1_ovf.sv
module shift1_ovf (
  input  logic top_bit,
  input  logic next_bit,
  input  logic signed_left,
  output logic ovf
);
  import shift1_pkg::*;

  always_comb begin
    ovf = signed_left & sign_escape(top_bit, next_bit);
  end
endmodule

// File: rtl/shift1_unit.sv
module shift1_unit #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] din,
  input  logic             shift_en,
  input  logic             shift_left,
  input  logic             arith_mode,
  output logic [WIDTH-1:0] dout,
  output logic             ovf_flag
);
  localparam int MSB = WIDTH - 1;

  // Named internal events for the checker
  logic [1:0] op_sel_w;
  logic       fill_bit_w;
  logic       signed_left_w;

  assign op_sel_w      = {shift_en, shift_left};
  assign signed_left_w = shift_en & shift_left & arith_mode;

  shift1_fill u_fill (
    .msb_in     (din[MSB]),
    .arith_mode (arith_mode),
    .fill_bit   (fill_bit_w)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_lane
    logic above_w;
    logic below_w;

    if (i == MSB) begin : g_top
      assign above_w = fill_bit_w;
    end else begin : g_mid_hi
      assign above_w = din[i+1];
    end

    if (i == 0) begin : g_bot
      assign below_w = 1'b0;
    end else begin : g_mid_lo
      assign below_w = din[i-1];
    end

    shift1_lane u_lane (
      .op_sel     (op_sel_w),
      .self_bit   (din[i]),
      .from_above (above_w),
      .from_below (below_w),
      .lane_out   (dout[i])
    );
  end

  shift1_ovf u_ovf (
    .top_bit     (din[MSB]),
    .next_bit    (din[MSB-1]),
    .signed_left (signed_left_w),
    .ovf         (ovf_flag)
  );
endmodule

// File: rtl/shift1_unit_chk.sv
module shift1_unit_chk #(
  parameter int WIDTH = 4
) (
  input logic [WIDTH-1:0] din,
  input logic             shift_en,
  input logic             shift_left,
  input logic             arith_mode,
  input logic [WIDTH-1:0] dout,
  input logic             ovf_flag,
  input logic             fill_bit_w,
  input logic             signed_left_w
);
  localparam int MSB = WIDTH - 1;

  always_comb begin
    if (!shift_en) begin
      AST_HOLD_PASS: assert (dout == din && !ovf_flag); // R1
    end
    if (shift_en && shift_left) begin
      AST_LEFT_ZERO_IN: assert (dout[0] == 1'b0 && dout[MSB:1] == din[MSB-1:0]); // R3
    end
    if (shift_en && !shift_left && !arith_mode) begin
      AST_RIGHT_ZERO_IN: assert (dout[MSB] == 1'b0 && fill_bit_w == 1'b0); // R2
    end
    if (shift_en && !shift_left && arith_mode) begin
      AST_RIGHT_SIGN_KEEP: assert (dout[MSB] == din[MSB]); // R4
    end
    if (signed_left_w) begin
      AST_OVF_SIGN_CHANGE: assert (ovf_flag == (dout[MSB] != din[MSB])); // R5
    end
    if (!arith_mode || !shift_left) begin
      AST_NO_OVERFLOW: assert (!ovf_flag); // R6
    end
  end
endmodule

bind shift1_unit shift1_unit_chk #(.WIDTH(WIDTH)) u_chk (
  .din           (din),
  .shift_en      (shift_en),
  .shift_left    (shift_left),
  .arith_mode    (arith_mode),
  .dout          (dout),
  .ovf_flag      (ovf_flag),
  .fill_bit_w    (fill_bit_w),
  .signed_left_w (signed_left_w)
);

// File: tb/shift1_unit_tb_top.sv
module shift1_unit_tb_top;

  logic clk = 1'b0;
  always #2 clk = ~clk; // 250 MHz

  logic [3:0] a4, y4;
  logic       en4, lf4, ar4, ov4;
  logic [7:0] a8, y8;
  logic       en8, lf8, ar8, ov8;

  int vectors = 0;
  int misses  = 0;

  shift1_unit #(.WIDTH(4)) dut_i (
    .din(a4), .shift_en(en4), .shift_left(lf4), .arith_mode(ar4),
    .dout(y4), .ovf_flag(ov4)
  );

  shift1_unit #(.WIDTH(8)) dut_w8_i (
    .din(a8), .shift_en(en8), .shift_left(lf8), .arith_mode(ar8),
    .dout(y8), .ovf_flag(ov8)
  );

  // Behavioural reference on plain integers
  function automatic void model(input int w, input int a, input bit en,
                                input bit lf, input bit ar,
                                output int exp, output bit ov);
    int mask, sv, r, rs;
    mask = (1 << w) - 1;
    sv   = (a >= (1 << (w - 1))) ? a - (1 << w) : a;
    ov   = 1'b0;
    if (!en)            r = a;
    else if (lf)        r = a << 1;
    else if (ar)        r = sv >>> 1;
    else                r = a >> 1;
    exp = r & mask;
    rs  = (exp >= (1 << (w - 1))) ? 1 : 0;
    if (en && lf && ar) ov = ((sv < 0) ? 1 : 0) != rs;
  endfunction

  function automatic string tag(input bit en, input bit lf, input bit ar);
    if (!en)     return "R1";
    if (lf)      return ar ? "R3/R5" : "R3/R6";
    return ar ? "R4/R6" : "R2/R6";
  endfunction

  task automatic apply(input int w, input int a, input bit en,
                       input bit lf, input bit ar);
    int exp, got;
    bit ov, gov;
    model(w, a, en, lf, ar, exp, ov);
    @(posedge clk);
    if (w == 4) begin a4 = 4'(a); en4 = en; lf4 = lf; ar4 = ar; end
    else        begin a8 = 8'(a); en8 = en; lf8 = lf; ar8 = ar; end
    @(negedge clk);
    got = (w == 4) ? int'(y4) : int'(y8);
    gov = (w == 4) ? ov4 : ov8;
    vectors++;
    if (got != exp || gov != ov) begin
      misses++;
      $display("FAIL %s R7 w=%0d din=%0h en=%0b lf=%0b ar=%0b: got dout=%0h ovf=%0b exp dout=%0h ovf=%0b",
               tag(en, lf, ar), w, a, en, lf, ar, got, gov, exp, ov);
    end
  endtask

  task automatic expect8(input string req, input int a, input bit lf,
                         input bit ar, input int exp, input bit ov);
    @(posedge clk);
    a8 = 8'(a); en8 = 1'b1; lf8 = lf; ar8 = ar;
    @(negedge clk);
    vectors++;
    if (int'(y8) != exp || ov8 != ov) begin
      misses++;
      $display("FAIL %s din=%0h: got dout=%0h ovf=%0b exp dout=%0h ovf=%0b",
               req, a, y8, ov8, exp, ov);
    end
  endtask

  initial begin
    a4 = '0; en4 = 0; lf4 = 0; ar4 = 0;
    a8 = '0; en8 = 0; lf8 = 0; ar8 = 0;
    // Idle state: zero word, hold (R1)
    apply(4, 0, 0, 0, 0);
    // Fixed cases at 8 bits
    expect8("R4", 8'hFB, 0, 1, 8'hFD, 0);
    expect8("R4", 8'hFD, 0, 1, 8'hFE, 0); // -3 -> -2
    expect8("R2", 8'hCB, 0, 0, 8'h65, 0);
    expect8("R3", 8'hCB, 1, 0, 8'h96, 0);
    expect8("R5", 8'hBF, 1, 1, 8'h7E, 1); // negative to positive
    expect8("R5", 8'h42, 1, 1, 8'h84, 1); // positive to negative
    expect8("R6", 8'h42, 1, 0, 8'h84, 0);
    expect8("R5", 8'hFB, 1, 1, 8'hF6, 0);
    // Exhaustive sweeps at both widths (R7)
    for (int w = 4; w <= 8; w += 4)
      for (int a = 0; a < (1 << w); a++)
        for (int s = 0; s < 8; s++)
          apply(w, a, s[2], s[1], s[0]);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    misses++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule